// File: doc/BRIEF.md
# Virtualization-Aware Interrupt Selector

This block decides which pending interrupt a hart should take next when the hart supports a hypervisor layer. It looks at the pending-interrupt vector, the machine-level and hypervisor-level delegation masks, the three global enable bits (machine, host supervisor, guest supervisor), the current privilege, the virtualization flag and the debug-mode flag. From these it names at most one interrupt, as a one-hot vector with a valid flag.

The choice is made in three tiers. First come interrupts that stay at machine level. Next come interrupts delegated to the host supervisor. Last come interrupts delegated further to a guest supervisor, and only while the hart runs virtualized. A tier is looked at only when every tier above it has no enabled candidate. Inside the winning tier a fixed cause ranking picks one interrupt. The result is registered, so it appears one clock after the inputs are sampled. Trap entry itself is done elsewhere.

Top module: `virt_irq_arbiter`

## Requirements
- R1: While reset is asserted and right after it, `take_o` is all zeros and `take_vld_o` is 0.
- R2: The outputs show the choice for the inputs sampled at the previous rising clock edge. `take_o` has at most one bit set, and `take_vld_o` is 1 exactly when a bit is set.
- R3: When no pending bit is set, nothing is selected.
- R4: Machine-tier candidates are the pending bits that are clear in the effective machine delegation mask. They are enabled when the privilege is below machine, or when it is machine and `m_ie_i` is 1. Privilege encoding: 2'b00 user, 2'b01 supervisor, 2'b11 machine. 2'b10 counts as below machine and above supervisor.
- R5: The host-supervisor tier is used only when the machine tier yields nothing. Its candidates are the delegated pending bits with the guest bits (2, 6, 10) removed. It is enabled when the privilege is user, or when it is supervisor and the selected SIE bit is 1. The SIE bit is `guest_sie_i` when `virt_i`=1 and `host_sie_i` when `virt_i`=0.
- R6: The guest tier is used only when `virt_i`=1 and both higher tiers yield nothing. Its candidates are the pending bits set in both the effective machine mask and `hdeleg_i`. It uses the same enable rule as R5.
- R7: Within a tier the ranking runs from first to last as: machine external (11), machine software (3), machine timer (7), supervisor external (9), supervisor software (1), supervisor timer (5), guest external (10), guest software (2), guest timer (6).
- R8: Causes at bit 16 and above rank ahead of all standard causes, with the higher index first.
- R9: Bits 0, 4, 8 and 12 to 15 of `pend_i` are never selected and do not affect the choice.
- R10: While `dbg_i` is 1, nothing is selected.
- R11: With `HYP_EN`=1, bits 2, 6, 10 and 12 of the machine delegation mask act as set whatever `mdeleg_i` holds.

Debug mode does not hold the selection. When `dbg_i` returns to 0, selection resumes on the next edge from the inputs sampled then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | XLEN | Pending-interrupt vector |
| mdeleg_i | input | XLEN | Machine-level delegation mask |
| hdeleg_i | input | XLEN | Hypervisor-level delegation mask |
| m_ie_i | input | 1 | Machine global interrupt enable |
| host_sie_i | input | 1 | Host supervisor interrupt enable |
| guest_sie_i | input | 1 | Guest supervisor interrupt enable |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Hart is running virtualized |
| dbg_i | input | 1 | Hart is in debug mode |
| take_o | output | XLEN | One-hot interrupt to take |
| take_vld_o | output | 1 | An interrupt is selected |

## Verification
The bench aims at cases where a higher tier holds pending bits that are disabled. A design that stops at the first non-empty tier, rather than the first enabled one, would then drop a lower-tier interrupt that should be taken. It pairs guest bits with a cleared `mdeleg_i` and `virt_i`=0. A design that fails to force the guest delegation would deliver them at machine level. It toggles `virt_i` to catch a swapped SIE source. It mixes custom, unranked and standard bits to catch a design that ranks by bit index rather than by the fixed order.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

    // standard cause bit positions
    localparam int SSI_BIT  = 1;
    localparam int VSSI_BIT = 2;
    localparam int MSI_BIT  = 3;
    localparam int STI_BIT  = 5;
    localparam int VSTI_BIT = 6;
    localparam int MTI_BIT  = 7;
    localparam int SEI_BIT  = 9;
    localparam int VSEI_BIT = 10;
    localparam int MEI_BIT  = 11;
    localparam int SGEI_BIT = 12;

    localparam int FIRST_CUSTOM = 16;
    localparam int NUM_RANKED   = 9;
    localparam int NUM_TIERS    = 3;
    localparam int TIER_M  = 0;
    localparam int TIER_HS = 1;
    localparam int TIER_VS = 2;

    localparam logic [15:0] GUEST16  = 16'((1 << VSSI_BIT) | (1 << VSTI_BIT) | (1 << VSEI_BIT));
    localparam logic [15:0] FORCED16 = GUEST16 | 16'(1 << SGEI_BIT);
    localparam logic [15:0] RANKED16 = GUEST16 | 16'((1 << SSI_BIT) | (1 << MSI_BIT) |
                                       (1 << STI_BIT) | (1 << MTI_BIT) |
                                       (1 << SEI_BIT) | (1 << MEI_BIT));

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    // cause at rank position r (0 = first)
    function automatic int rank_cause(input int r);
        case (r)
            0:       return MEI_BIT;
            1:       return MSI_BIT;
            2:       return MTI_BIT;
            3:       return SEI_BIT;
            4:       return SSI_BIT;
            5:       return STI_BIT;
            6:       return VSEI_BIT;
            7:       return VSSI_BIT;
            default: return VSTI_BIT;
        endcase
    endfunction

endpackage

// File: rtl/irqsel_gate.sv
module irqsel_gate #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] cand_i,
    input  logic            en_i,
    output logic [XLEN-1:0] live_o,
    output logic            any_o
);
    always_comb begin
        live_o = en_i ? cand_i : '0;
        any_o  = |live_o;
    end
endmodule

// File: rtl/irqsel_pick.sv
module irqsel_pick
    import irqsel_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] set_i,
    output logic [XLEN-1:0] onehot_o
);
    logic hit_custom;
    logic [XLEN-1:0] custom_oh;

    generate
        if (XLEN > FIRST_CUSTOM) begin : g_custom
            always_comb begin
                custom_oh  = '0;
                hit_custom = 1'b0;
                for (int i = XLEN - 1; i >= FIRST_CUSTOM; i--) begin
                    if (!hit_custom && set_i[i]) begin
                        custom_oh[i] = 1'b1;
                        hit_custom   = 1'b1;
                    end
                end
            end
        end else begin : g_nocustom
            always_comb begin
                custom_oh  = '0;
                hit_custom = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        logic found;
        int   idx;
        onehot_o = custom_oh;
        found    = hit_custom;
        for (int r = 0; r < NUM_RANKED; r++) begin
            idx = rank_cause(r);
            if (!found && set_i[idx]) begin
                onehot_o[idx] = 1'b1;
                found         = 1'b1;
            end
        end
    end
endmodule

// File: rtl/virt_irq_arbiter.sv
module virt_irq_arbiter
    import irqsel_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter bit HYP_EN = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] mdeleg_i,
    input  logic [XLEN-1:0] hdeleg_i,
    input  logic            m_ie_i,
    input  logic            host_sie_i,
    input  logic            guest_sie_i,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic            dbg_i,
    output logic [XLEN-1:0] take_o,
    output logic            take_vld_o
);
    localparam logic [XLEN-1:0] LOW_MASK    = XLEN'(16'hFFFF);
    localparam logic [XLEN-1:0] LEGAL_MASK  = XLEN'(RANKED16) | ~LOW_MASK;
    localparam logic [XLEN-1:0] GUEST_MASK  = XLEN'(GUEST16);
    localparam logic [XLEN-1:0] FORCED_MASK = HYP_EN ? XLEN'(FORCED16) : '0;

    typedef struct packed {
        logic [XLEN-1:0] take;
        logic            vld;
    } sel_t;

    sel_t sel_d, sel_q;

    priv_e           priv;
    logic [XLEN-1:0] pend_ok, mdel_eff, chosen, picked;
    logic            below_m, sup_en;
    logic [XLEN-1:0] tier_cand [NUM_TIERS];
    logic            tier_en   [NUM_TIERS];
    logic [XLEN-1:0] tier_live [NUM_TIERS];
    logic            tier_any  [NUM_TIERS];

    always_comb begin
        priv     = priv_e'(priv_i);
        pend_ok  = pend_i & LEGAL_MASK;
        mdel_eff = mdeleg_i | FORCED_MASK;
        below_m  = (priv != PRIV_M);
        sup_en   = (priv == PRIV_U) ||
                   ((priv == PRIV_S) && (virt_i ? guest_sie_i : host_sie_i));

        tier_cand[TIER_M]  = pend_ok & ~mdel_eff;
        tier_en[TIER_M]    = below_m || m_ie_i;
        tier_cand[TIER_HS] = pend_ok & mdel_eff & ~GUEST_MASK;
        tier_en[TIER_HS]   = sup_en;
        tier_cand[TIER_VS] = pend_ok & mdel_eff & hdeleg_i;
        tier_en[TIER_VS]   = sup_en && virt_i;
    end

    generate
        for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
            irqsel_gate #(.XLEN(XLEN)) u_gate (
                .cand_i (tier_cand[t]),
                .en_i   (tier_en[t]),
                .live_o (tier_live[t]),
                .any_o  (tier_any[t])
            );
        end
    endgenerate

    // the lowest-numbered non-empty tier wins
    always_comb begin
        chosen = '0;
        for (int t = NUM_TIERS - 1; t >= 0; t--) begin
            if (tier_any[t]) chosen = tier_live[t];
        end
    end

    irqsel_pick #(.XLEN(XLEN)) u_pick (
        .set_i    (chosen),
        .onehot_o (picked)
    );

    always_comb begin
        sel_d.take = dbg_i ? '0 : picked;
        sel_d.vld  = |sel_d.take;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sel_q <= '0;
        else         sel_q <= sel_d;
    end

    assign take_o     = sel_q.take;
    assign take_vld_o = sel_q.vld;

    // R2
    take_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(take_o) && (take_vld_o == (take_o != '0)));

    // R3
    idle_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_i == '0) |=> !take_vld_o);

    // R4
    m_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (priv_i == 2'b11 && !m_ie_i) |=> !take_vld_o);

    // R6
    guest_novirt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (HYP_EN && !virt_i) |=> ((take_o & GUEST_MASK) == '0));

    // R9
    unranked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o & ~LEGAL_MASK) == '0);

    // R10
    debug_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_i |=> !take_vld_o);

endmodule

// File: tb/virt_irq_arbiter_tb.sv
`timescale 1ns/1ps
module virt_irq_arbiter_tb;
    localparam int XL = 64;
    localparam bit HYP = 1'b1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [XL-1:0] pend = '0, mdel = '0, hdel = '0;
    logic          mie = 0, hsie = 0, gsie = 0, virt = 0, dbg = 0;
    logic [1:0]    priv = 2'b11;
    logic [XL-1:0] take;
    logic          vld;
    logic [XL-1:0] model_q;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    virt_irq_arbiter #(.XLEN(XL), .HYP_EN(HYP)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .mdeleg_i(mdel), .hdeleg_i(hdel),
        .m_ie_i(mie), .host_sie_i(hsie), .guest_sie_i(gsie), .priv_i(priv),
        .virt_i(virt), .dbg_i(dbg), .take_o(take), .take_vld_o(vld)
    );

    localparam int ORD[9] = '{11, 3, 7, 9, 1, 5, 10, 2, 6};

    function automatic bit ranked(int b);
        foreach (ORD[k]) if (ORD[k] == b) return 1;
        return 0;
    endfunction

    function automatic logic [XL-1:0] ref_sel();
        logic [XL-1:0] grp [3];
        bit en [3];
        bit sen;
        logic [XL-1:0] use_set;
        logic [XL-1:0] res;
        if (!rst_n || dbg) return '0;
        for (int g = 0; g < 3; g++) grp[g] = '0;
        for (int b = 0; b < XL; b++) begin
            bit legal, dl, gst;
            legal = (b >= 16) || ranked(b);
            gst   = (b == 2 || b == 6 || b == 10);
            dl    = mdel[b] || (HYP && (gst || b == 12));
            if (pend[b] && legal) begin
                if (!dl) grp[0][b] = 1;
                if (dl && !gst) grp[1][b] = 1;
                if (dl && hdel[b]) grp[2][b] = 1;
            end
        end
        sen = (priv == 2'b00) || (priv == 2'b01 && (virt ? gsie : hsie));
        en[0] = (priv != 2'b11) || mie;
        en[1] = sen;
        en[2] = sen && virt;
        use_set = '0;
        for (int g = 2; g >= 0; g--) if (en[g] && grp[g] != '0) use_set = grp[g];
        res = '0;
        for (int b = XL - 1; b >= 16; b--) if (use_set[b]) begin res[b] = 1; return res; end
        foreach (ORD[k]) if (use_set[ORD[k]]) begin res[ORD[k]] = 1; return res; end
        return res;
    endfunction

    // every-clock reference comparison (R2)
    always @(posedge clk) model_q <= ref_sel();

    always @(negedge clk) if (rst_n && !done) begin
        n_chk++;
        if (take !== model_q || vld !== (model_q != '0)) begin
            n_bad++;
            $display("FAIL R2 model: actual take=%h vld=%0b expected take=%h", take, vld, model_q);
        end
    end

    task automatic set_in(input logic [XL-1:0] p, input logic [XL-1:0] md, input logic [XL-1:0] hd,
                          input logic [1:0] pv, input bit v, input bit m, input bit hs, input bit gs,
                          input bit d);
        @(negedge clk);
        pend = p; mdel = md; hdel = hd; priv = pv; virt = v;
        mie = m; hsie = hs; gsie = gs; dbg = d;
    endtask

    task automatic expect_idx(input int idx, input string req);
        logic [XL-1:0] e;
        @(negedge clk);
        #1;
        e = (idx < 0) ? '0 : (XL'(1) << idx);
        n_chk++;
        if (take !== e || vld !== (idx >= 0)) begin
            n_bad++;
            $display("FAIL %s: actual take=%h vld=%0b expected take=%h", req, take, vld, e);
        end
    endtask

    function automatic logic [XL-1:0] bv(int b);
        return XL'(1) << b;
    endfunction

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (take !== '0 || vld !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: actual take=%h vld=%0b expected 0", take, vld);
        end
        rst_n = 1'b1;
        expect_idx(-1, "R1 after release");

        set_in('0, '0, '0, 2'b00, 0, 1, 1, 1, 0);                  expect_idx(-1, "R3");
        set_in(bv(7) | bv(3), '0, '0, 2'b11, 0, 1, 0, 0, 0);        expect_idx(3, "R4 R7 MSIP over MTIP");
        set_in(bv(7), '0, '0, 2'b11, 0, 0, 1, 1, 0);                expect_idx(-1, "R4 MIE off at M");
        set_in(bv(11), '0, '0, 2'b01, 0, 0, 0, 0, 0);               expect_idx(11, "R4 below M");
        set_in(bv(5) | bv(9), bv(5) | bv(9), '0, 2'b01, 0, 0, 1, 0, 0); expect_idx(9, "R5 R7 SEIP over STIP");
        set_in(bv(5) | bv(9), bv(5) | bv(9), '0, 2'b01, 0, 0, 0, 1, 0); expect_idx(-1, "R5 host SIE off");
        set_in(bv(5) | bv(9), bv(5) | bv(9), '0, 2'b01, 1, 0, 0, 1, 0); expect_idx(9, "R5 guest SIE with V");
        set_in(bv(7) | bv(9), bv(9), '0, 2'b01, 0, 0, 1, 0, 0);     expect_idx(7, "R5 machine tier first");
        set_in(bv(7) | bv(1), bv(1), '0, 2'b01, 0, 1, 1, 1, 0);     expect_idx(7, "R4 R5 M tier beats S order");
        set_in(bv(6) | bv(2), bv(1), bv(2) | bv(6) | bv(10), 2'b00, 1, 0, 0, 0, 0); expect_idx(2, "R6 R7 VSSIP over VSTIP");
        set_in(bv(6) | bv(10), '0, bv(2) | bv(6) | bv(10), 2'b00, 1, 0, 0, 0, 0); expect_idx(10, "R6 R7 VSEIP first");
        set_in(bv(6) | bv(2), bv(1), bv(2) | bv(6) | bv(10), 2'b00, 0, 0, 0, 0, 0); expect_idx(-1, "R6 no virt");
        set_in(bv(1) | bv(10), bv(1), bv(10), 2'b00, 1, 0, 0, 0, 0); expect_idx(1, "R6 HS before VS");
        set_in(bv(10), '0, '0, 2'b00, 1, 0, 0, 0, 0);               expect_idx(-1, "R6 hdeleg clear");
        set_in(bv(20) | bv(17) | bv(11), '0, '0, 2'b00, 0, 0, 0, 0, 0); expect_idx(20, "R8 custom first");
        set_in(bv(63) | bv(16), bv(16), '0, 2'b00, 0, 0, 0, 0, 0);  expect_idx(63, "R8 top custom");
        set_in(bv(0) | bv(4) | bv(8) | bv(13) | bv(15), '0, '0, 2'b00, 0, 1, 1, 1, 0); expect_idx(-1, "R9 unranked");
        set_in(bv(4) | bv(5), bv(4), '0, 2'b00, 0, 0, 0, 0, 0);     expect_idx(5, "R9 no tier effect");
        set_in(bv(11), '0, '0, 2'b00, 0, 1, 1, 1, 1);               expect_idx(-1, "R10 debug");
        set_in(bv(11), '0, '0, 2'b00, 0, 1, 1, 1, 0);               expect_idx(11, "R10 release");
        set_in(bv(2), '0, '0, 2'b11, 0, 1, 1, 1, 0);                expect_idx(-1, "R11 forced delegation");
        set_in(bv(2), '0, bv(2), 2'b00, 1, 0, 0, 0, 0);             expect_idx(2, "R11 guest via forced mask");
        set_in(bv(9), bv(9), '0, 2'b10, 0, 0, 1, 1, 0);             expect_idx(-1, "R4 reserved privilege");

        for (int n = 0; n < 400; n++) begin
            logic [XL-1:0] p;
            p = XL'($urandom() & 32'h1FFF);
            if ($urandom() % 4 == 0) p[16 + ($urandom() % 48)] = 1'b1;
            set_in(p, XL'($urandom()) | (XL'($urandom()) << 32), XL'($urandom()),
                   2'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
                   1'($urandom()), ($urandom() % 8) == 0);
        end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule